// File: doc/BRIEF.md
# Tagged Boot Image Loader

This block turns a stream of 48-bit boot image words into writes on a target memory write port. The image is a chain of blocks. Each block opens with two preamble words: a type tag, then a destination address and a word count. The tag decides two things. It selects zero-fill or copy-from-stream, and it selects the width of each memory write. Zero-fill blocks take no payload from the stream. Copy blocks take one stream word for every destination word.

A terminal tag ends parsing and starts a closing overlay. The loader keeps the next stream word aside. It then copies a fixed number of words onto the base of program memory, overwriting the area that held the loader's own code. Last, it writes the kept word to the entry slot at base+4 and reports that address as the entry point. An unknown tag stops the loader in a sticky error state.

The stream uses a valid/ready handshake. The write port has a ready input, and a write completes in a cycle where write-enable and ready are both high.

Top module: `boot_ldr`

## Requirements
- R1: Word 1 of a preamble carries the tag in bits [15:0], and its bits [47:16] are ignored. Word 2 carries the destination address in bits [47:16] and the word count in bits [15:0].
- R2: Tags 0x1, 0x2, 0x3, 0x7, 0x8, 0x9 and 0xA write zero to `count` consecutive addresses starting at the destination, one address per cycle while the port is ready. They accept no stream words while doing so.
- R3: Tags 0x4, 0x5, 0x6, 0xB, 0xC, 0xD and 0xE accept one stream word per destination word and write it to consecutive addresses starting at the destination.
- R4: The width code is 0 for 16-bit, 1 for 32-bit, 2 for 40-bit and 3 for 48-bit. Tags 0x1, 0x4, 0x7 and 0xB use code 0. Tags 0x2, 0x5, 0x8 and 0xC use code 1. Tags 0x3, 0x6, 0x9 and 0xD use code 2. Tags 0xA and 0xE use code 3. Written data bits above the selected width are zero.
- R5: A block with a count of zero issues no writes, and the next stream word is taken as a new tag.
- R6: Once a block's last write completes, the next stream word accepted is the next block's tag.
- R7: On tag 0x0 the loader accepts one more word and holds it. It then copies the next OVL_WORDS stream words, at width code 3, to addresses BASE_ADDR upward.
- R8: After the overlay, the held word is written at width code 3 to BASE_ADDR+4. `done_o` then rises and stays high, and `entry_o` reads BASE_ADDR+4. From then on the loader issues no writes and accepts no stream words.
- R9: A tag outside 0x0 to 0xE, with all 16 tag bits compared, raises `err_o`, which stays high until reset. No writes or stream accepts follow it.
- R10: While write-enable is high and `mem_ready_i` is low, write-enable stays high and the address does not change. When the port is ready and the stream is valid, the loader inserts no idle cycle: each cycle from reset to done accepts a word or completes a write.
- R11: After reset, no write is pending, `done_o` and `err_o` are low, and the loader is ready for a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Stream word valid |
| src_data_i | input | 48 | Stream word |
| src_ready_o | output | 1 | Loader accepts the stream word |
| mem_we_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write address |
| mem_data_o | output | 48 | Write data, trimmed to the width |
| mem_width_o | output | 2 | Width code |
| mem_ready_i | input | 1 | Write port accepts the request |
| done_o | output | 1 | Image loaded |
| err_o | output | 1 | Unknown tag seen |
| entry_o | output | 32 | Entry address, valid with done_o |

## Verification
The assertions check these on every cycle:
- A stalled write holds its request and address.
- Written data carries no bits above its width code.
- The done and error states are sticky and silent on both interfaces.
- The entry address matches while done is high.

Only the bench's scenarios can show the rest, since it depends on the image contents:
- Each write lands at the right address with the right word.
- Zero-fill blocks leave the stream untouched.
- A zero count skips straight to the next tag.
- The overlay and the entry patch come in the right order.
- The loader stops consuming after the last word it needs.
- At full rate, no cycle is idle.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
  localparam int WORD_W = 48;

  typedef enum logic [1:0] {W16 = 2'd0, W32 = 2'd1, W40 = 2'd2, W48 = 2'd3} wsel_e;

  typedef enum logic [3:0] {
    S_TAG, S_HDR, S_FILL, S_COPY, S_HOLD, S_OVL, S_PATCH, S_DONE, S_ERR
  } st_e;

  typedef struct packed {
    logic  legal;
    logic  last_t;
    logic  zero;
    wsel_e width;
  } tag_info_t;

  function automatic logic [WORD_W-1:0] trim(input logic [WORD_W-1:0] d, input wsel_e w);
    case (w)
      W16:     trim = {32'h0, d[15:0]};
      W32:     trim = {16'h0, d[31:0]};
      W40:     trim = {8'h0, d[39:0]};
      default: trim = d;
    endcase
  endfunction
endpackage

// File: rtl/boot_ldr_tag_dec.sv
module boot_ldr_tag_dec
  import boot_ldr_pkg::*;
#(
  parameter int TAGW = 16
) (
  input  logic [TAGW-1:0] tag_i,
  output tag_info_t       info_o
);
  logic hi_zero;
  assign hi_zero = (tag_i[TAGW-1:4] == '0);

  always_comb begin
    info_o = '{legal: 1'b0, last_t: 1'b0, zero: 1'b0, width: W48};
    if (hi_zero) begin
      case (tag_i[3:0])
        4'h0: begin info_o.legal = 1'b1; info_o.last_t = 1'b1; end
        4'h1, 4'h2, 4'h3, 4'h7, 4'h8, 4'h9, 4'hA: begin
          info_o.legal = 1'b1; info_o.zero = 1'b1;
        end
        4'h4, 4'h5, 4'h6, 4'hB, 4'hC, 4'hD, 4'hE: info_o.legal = 1'b1;
        default: info_o.legal = 1'b0;
      endcase
      case (tag_i[3:0])
        4'h1, 4'h4, 4'h7, 4'hB: info_o.width = W16;
        4'h2, 4'h5, 4'h8, 4'hC: info_o.width = W32;
        4'h3, 4'h6, 4'h9, 4'hD: info_o.width = W40;
        default:                info_o.width = W48;
      endcase
    end
  end
endmodule

// File: rtl/boot_ldr_walk.sv
module boot_ldr_walk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      cnt_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/boot_ldr.sv
module boot_ldr
  import boot_ldr_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            CW        = 16,
  parameter int            TAGW      = 16,
  parameter logic [AW-1:0] BASE_ADDR = 'h2_0000,
  parameter int            OVL_WORDS = 256,
  parameter int            ENTRY_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_valid_i,
  input  logic [WORD_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic [1:0]        mem_width_o,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic              err_o,
  output logic [AW-1:0]     entry_o
);
  localparam logic [CW-1:0] OVL_CNT = CW'(OVL_WORDS);
  localparam logic [AW-1:0] ENTRY   = BASE_ADDR + AW'(ENTRY_OFS);

  st_e               st_q, st_d;
  tag_info_t         info;
  logic              zero_q;
  wsel_e             width_q;
  logic [WORD_W-1:0] held_q;
  logic              acc, wr, ld, last;
  logic [AW-1:0]     ld_addr, walk_addr;
  logic [CW-1:0]     ld_cnt, hdr_cnt;

  boot_ldr_tag_dec #(.TAGW(TAGW)) u_dec (
    .tag_i (src_data_i[TAGW-1:0]),
    .info_o(info)
  );

  assign hdr_cnt = src_data_i[CW-1:0];
  assign ld      = acc && (st_q == S_HDR || st_q == S_HOLD);
  assign ld_addr = (st_q == S_HOLD) ? BASE_ADDR : src_data_i[WORD_W-1 -: AW];
  assign ld_cnt  = (st_q == S_HOLD) ? OVL_CNT : hdr_cnt;

  boot_ldr_walk #(.AW(AW), .CW(CW)) u_walk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .addr_i(ld_addr),
    .cnt_i (ld_cnt),
    .step_i(wr && st_q != S_PATCH),
    .addr_o(walk_addr),
    .last_o(last)
  );

  always_comb begin
    src_ready_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = walk_addr;
    mem_data_o  = '0;
    mem_width_o = W48;
    case (st_q)
      S_TAG, S_HDR, S_HOLD: src_ready_o = 1'b1;
      S_FILL: begin
        mem_we_o    = 1'b1;
        mem_width_o = width_q;
      end
      S_COPY: begin
        src_ready_o = mem_ready_i;
        mem_we_o    = src_valid_i;
        mem_width_o = width_q;
        mem_data_o  = trim(src_data_i, width_q);
      end
      S_OVL: begin
        src_ready_o = mem_ready_i;
        mem_we_o    = src_valid_i;
        mem_data_o  = src_data_i;
      end
      S_PATCH: begin
        mem_we_o   = 1'b1;
        mem_addr_o = ENTRY;
        mem_data_o = held_q;
      end
      default: ;
    endcase
  end

  assign acc = src_valid_i && src_ready_o;
  assign wr  = mem_we_o && mem_ready_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_TAG:   if (acc) st_d = !info.legal ? S_ERR : (info.last_t ? S_HOLD : S_HDR);
      S_HDR:   if (acc) st_d = (hdr_cnt == '0) ? S_TAG : (zero_q ? S_FILL : S_COPY);
      S_FILL,
      S_COPY:  if (wr && last) st_d = S_TAG;
      S_HOLD:  if (acc) st_d = S_OVL;
      S_OVL:   if (wr && last) st_d = S_PATCH;
      S_PATCH: if (wr) st_d = S_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_TAG;
      zero_q  <= 1'b0;
      width_q <= W48;
      held_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_TAG && acc) begin
        zero_q  <= info.zero;
        width_q <= info.width;
      end
      if (st_q == S_HOLD && acc) held_q <= src_data_i;
    end
  end

  assign done_o  = (st_q == S_DONE);
  assign err_o   = (st_q == S_ERR);
  assign entry_o = done_o ? ENTRY : '0;
endmodule

// File: rtl/boot_ldr_chk.sv
module boot_ldr_chk #(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] BASE_ADDR = 'h2_0000,
  parameter int            ENTRY_OFS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_ready_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [47:0]   mem_data_o,
  input logic [1:0]    mem_width_o,
  input logic          mem_ready_i,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] entry_o
);
  localparam logic [AW-1:0] ENTRY = BASE_ADDR + AW'(ENTRY_OFS);

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && !mem_ready_i |=> mem_we_o && $stable(mem_addr_o)); // R10
  AST_TRIM_16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_width_o == 2'd0 |-> mem_data_o[47:16] == '0); // R4
  AST_TRIM_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_width_o == 2'd1 |-> mem_data_o[47:32] == '0); // R4
  AST_TRIM_40: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && mem_width_o == 2'd2 |-> mem_data_o[47:40] == '0); // R4
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_we_o && !src_ready_o && !done_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o && !src_ready_o && entry_o == ENTRY); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R8
endmodule

bind boot_ldr boot_ldr_chk #(.AW(AW), .BASE_ADDR(BASE_ADDR), .ENTRY_OFS(ENTRY_OFS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_ready_o(src_ready_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .mem_width_o(mem_width_o),
  .mem_ready_i(mem_ready_i),
  .done_o     (done_o),
  .err_o      (err_o),
  .entry_o    (entry_o)
);

// File: tb/sim_boot_ldr.sv
`timescale 1ns/1ps
module sim_boot_ldr;
  localparam logic [31:0] BASE = 32'h2_0000;
  localparam int          NOVL = 256;

  typedef struct packed {
    logic [1:0]  w;
    logic [31:0] a;
    logic [47:0] d;
  } wr_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_valid_i = 1'b0;
  logic [47:0] src_data_i = '0;
  logic        src_ready_o;
  logic        mem_we_o;
  logic [31:0] mem_addr_o;
  logic [47:0] mem_data_o;
  logic [1:0]  mem_width_o;
  logic        mem_ready_i = 1'b0;
  logic        done_o, err_o;
  logic [31:0] entry_o;

  int n_chk = 0, n_fail = 0;
  logic [47:0] str_q[$];
  wr_t         exp_q[$];
  string       req_q[$];
  int          n_words, n_fills;

  always #2.5 clk_i = ~clk_i;

  boot_ldr u0 (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] wcode(input int t);
    case (t)
      1, 4, 7, 11: return 2'd0;
      2, 5, 8, 12: return 2'd1;
      3, 6, 9, 13: return 2'd2;
      default:     return 2'd3;
    endcase
  endfunction

  function automatic logic [47:0] mask(input logic [47:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return d & 48'h0000_0000_FFFF;
      2'd1:    return d & 48'h0000_FFFF_FFFF;
      2'd2:    return d & 48'h00FF_FFFF_FFFF;
      default: return d;
    endcase
  endfunction

  function automatic logic [47:0] rnd48();
    return {$urandom(), $urandom()};
  endfunction

  task automatic push_word(input logic [47:0] w);
    str_q.push_back(w);
    n_words++;
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [47:0] d,
                           input logic [1:0] w, input string r);
    exp_q.push_back('{w: w, a: a, d: d});
    req_q.push_back(r);
  endtask

  // R1: junk in upper bits of the tag word
  task automatic add_block(input int t, input logic [31:0] a, input int cnt);
    bit zero = (t inside {1, 2, 3, 7, 8, 9, 10});
    push_word({16'hA5C3, $urandom() & 32'hFFFF_0000 | 32'(t)});
    push_word({a, 16'(cnt)});
    for (int i = 0; i < cnt; i++) begin
      if (zero) begin
        expect_wr(a + 32'(i), '0, wcode(t), "R2");
        n_fills++;
      end else begin
        logic [47:0] p = rnd48();
        push_word(p);
        expect_wr(a + 32'(i), mask(p, wcode(t)), wcode(t), "R3");
      end
    end
  endtask

  task automatic add_final();
    logic [47:0] h = rnd48();
    push_word(48'h0);
    push_word(h);
    for (int i = 0; i < NOVL; i++) begin
      logic [47:0] p = rnd48();
      push_word(p);
      expect_wr(BASE + 32'(i), p, 2'd3, "R7");
    end
    expect_wr(BASE + 32'd4, h, 2'd3, "R8");
  endtask

  task automatic reset_dut();
    str_q.delete(); exp_q.delete(); req_q.delete();
    n_words = 0; n_fills = 0;
    rst_ni = 1'b0; src_valid_i = 1'b0; mem_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(input bit full, input bit exp_err, input int exp_cyc, input int leftover);
    int cyc = 0, pre = 0, tail = 0;
    bit took = 1'b0, ended = 1'b0;
    forever begin
      @(negedge clk_i);
      if (!(src_valid_i && !took))
        src_valid_i = (str_q.size() > 0) && (full || $urandom_range(3) != 0);
      src_data_i  = src_valid_i ? str_q[0] : '0;
      mem_ready_i = full || ($urandom_range(3) != 0);
      #2;
      took = src_valid_i && src_ready_o;
      if (mem_we_o && mem_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected write addr", 64'(mem_addr_o), 64'h0);
        end else begin
          wr_t e = exp_q.pop_front();
          string r = req_q.pop_front();
          check({mem_width_o, mem_addr_o, mem_data_o} == e, r, "write {w,a,d}",
                64'({mem_addr_o, mem_data_o[31:0]}), 64'({e.a, e.d[31:0]}));
          if (mem_data_o[47:32] != e.d[47:32] || mem_width_o != e.w)
            check(1'b0, r, "write upper/width", 64'({mem_width_o, mem_data_o}), 64'({e.w, e.d}));
        end
      end
      if (took) void'(str_q.pop_front());
      if (err_o && !exp_err) check(1'b0, "R9", "spurious error", 64'(err_o), 64'h0);
      if (!done_o && !err_o && !ended) pre++;
      if (done_o || err_o) ended = 1'b1;
      if (ended) tail++;
      cyc++;
      if (tail >= 20) break;
      if (cyc > 20000) begin
        check(1'b0, "R10", "watchdog", 64'(cyc), 64'h0);
        break;
      end
    end
    check(exp_q.size() == 0, "R6", "writes missing", 64'(exp_q.size()), 64'h0);
    check(done_o == !exp_err, "R8", "done_o", 64'(done_o), 64'(!exp_err));
    check(err_o == exp_err, "R9", "err_o", 64'(err_o), 64'(exp_err));
    check(str_q.size() == leftover, "R8", "stream words left", 64'(str_q.size()), 64'(leftover));
    check(!src_ready_o && !mem_we_o, "R9", "quiet after end", 64'({src_ready_o, mem_we_o}), 64'h0);
    if (!exp_err) check(entry_o == BASE + 32'd4, "R8", "entry_o", 64'(entry_o), 64'(BASE + 32'd4));
    if (exp_cyc > 0) check(pre == exp_cyc, "R10", "cycles to done", 64'(pre), 64'(exp_cyc));
  endtask

  task automatic image_all_tags();
    for (int t = 1; t <= 14; t++)
      add_block(t, 32'h1000 * t, (t == 4) ? 0 : (t % 3) + 1); // R5: tag 4 with count 0
    add_block(5, 32'h9000, 0);                                // R5
    add_block(14, 32'hA000, 3);                               // R6: back-to-back
    add_final();
    push_word(rnd48()); // must remain unconsumed
  endtask

  initial begin
    // R11: reset state
    rst_ni = 1'b0;
    #1;
    check(!mem_we_o, "R11", "we in reset", 64'(mem_we_o), 64'h0);
    check(!done_o && !err_o, "R11", "flags in reset", 64'({done_o, err_o}), 64'h0);
    check(src_ready_o, "R11", "ready for tag", 64'(src_ready_o), 64'h1);

    // full rate: every cycle accepts or writes (R10)
    reset_dut();
    image_all_tags();
    run(1'b1, 1'b0, (n_words - 1) + n_fills + 1, 1);

    // random gaps on both sides
    reset_dut();
    image_all_tags();
    run(1'b0, 1'b0, 0, 1);

    // R9: bad tag after a valid block
    reset_dut();
    add_block(5, 32'h300, 2);
    push_word(48'h0F);
    push_word(rnd48());
    push_word(rnd48());
    run(1'b0, 1'b1, 0, 2);

    // R9: upper tag bit set, low nibble zero
    reset_dut();
    push_word(48'h0010);
    push_word(rnd48());
    push_word(rnd48());
    run(1'b1, 1'b1, 0, 2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule